// File: doc/BRIEF.md
# I2C Target Front End with High-Speed Entry

This block is the bus-facing part of an I2C target. It lives in the system clock domain and sees the bus only through synchronized copies of SCL and SDA. It finds bus conditions, shifts in bytes with the most significant bit first, and decides whether the first byte of a frame is addressed to it. If it is, the block acknowledges by pulling SDA low through an open-drain enable. Every later byte of a write goes to a command layer, tagged with its position in the frame. On a read, the block takes bytes from the command layer and shifts them out.

Two addresses are answered. The first is the device address: a fixed five-bit prefix followed by two strap bits. The straps are captured once, on the first clock after reset. The second is a broadcast address, which is answered for writes only. A high-speed entry code seen right after START is recognised without any acknowledge. It raises a mode flag that survives repeated STARTs and is cleared by STOP.

Top module: `i2cs_front`

## Requirements
- R1: After reset, sda_oe is 0, hs_mode is 0, and no pulse output (start_seen, stop_seen, byte_valid, ack_done, tx_load) is high.
- R2: An SDA fall while SCL is high gives one start_seen pulse. An SDA rise while SCL is high gives one stop_seen pulse.
- R3: A first byte equal to 1001_1 followed by the captured strap bits (addr_pins[1] then addr_pins[0]) and then R/W is acknowledged. The straps are sampled once after reset, so later changes on addr_pins do not change the address.
- R4: A first byte that matches neither address is not acknowledged. This includes the general call 0x00 and the 10-bit prefix 0xF0. All further bytes up to the next START are then ignored: no acknowledge and no byte_valid.
- R5: The broadcast byte 0x90 is acknowledged as a write. The byte 0x91 (broadcast with read) is not acknowledged.
- R6: A first byte of the form 00001xxx is not acknowledged and sets hs_mode. Repeated STARTs keep hs_mode set. STOP clears it.
- R7: In a write, every data byte is acknowledged. For each one, byte_valid pulses with rx_byte, and byte_index counts 0, 1, 2 and so on within the frame. first_after_addr is high only when byte_index is 0.
- R8: ack_done pulses once at the SCL fall that ends each acknowledge slot. This covers the slots the block drives and the master's slots during a read.
- R9: On a read, tx_byte is sampled at the end of the address acknowledge (tx_load pulses) and shifted out MSB first. A 0 bit is driven as sda_oe = 1.
- R10: During a read, an acknowledge from the master loads and sends the next tx_byte. A NACK releases SDA (sda_oe = 0) and loads nothing more until the next START or STOP.
- R11: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_pins | input | 2 | Address strap bits, captured once after reset |
| tx_byte | input | 8 | Byte to send on a read |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| hs_mode | output | 1 | High-speed entry seen and not yet ended by STOP |
| start_seen | output | 1 | Pulse on START or repeated START |
| stop_seen | output | 1 | Pulse on STOP |
| byte_valid | output | 1 | Pulse: rx_byte holds a received data byte |
| rx_byte | output | 8 | Last received data byte |
| byte_index | output | IDX_W | Position of rx_byte among the data bytes of the frame |
| first_after_addr | output | 1 | rx_byte is the first byte after the address |
| ack_done | output | 1 | Pulse at the SCL fall that ends an acknowledge slot |
| tx_load | output | 1 | Pulse when tx_byte is sampled |

## Verification
Address matching is tried with the own address under the strapped pins and under changed pins, with the broadcast write and read bytes, with the general call and with a 10-bit prefix. Together these separate the prefix compare, the strap capture, the read/write qualifier on broadcast, and the silent idle state after a mismatch. Multi-byte writes with distinct data show ordering and index counting. A high-speed code followed by repeated STARTs and a STOP isolates the lifetime of the mode flag. A read with one master ACK and then a NACK separates byte reloading from bus release, and a further read after the NACK shows that the released line reads all ones.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_WAIT, ST_ACK, ST_TX, ST_MACK
  } st_e;
  localparam logic [4:0] DEV_PREFIX = 5'b10011;
  localparam logic [7:0] BCAST_WR   = 8'h90;
  localparam logic [4:0] HS_CODE    = 5'b00001;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= '1;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_front.sv
module i2cs_front
  import i2cs_pkg::*;
#(
  parameter logic [4:0] ADDR_PREFIX = DEV_PREFIX,
  parameter logic [7:0] BCAST       = BCAST_WR,
  parameter int         IDX_W       = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [1:0]       addr_pins,
  input  logic [7:0]       tx_byte,
  output logic             sda_oe,
  output logic             hs_mode,
  output logic             start_seen,
  output logic             stop_seen,
  output logic             byte_valid,
  output logic [7:0]       rx_byte,
  output logic [IDX_W-1:0] byte_index,
  output logic             first_after_addr,
  output logic             ack_done,
  output logic             tx_load
);
  logic [1:0] bus_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sda_in, scl_in}), .q(bus_s));
  assign scl_s = bus_s[0];
  assign sda_s = bus_s[1];

  i2cs_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c));

  st_e st, st_n;
  logic [2:0] cnt, cnt_n;
  logic [6:0] sr, sr_n, txsr, txsr_n;
  logic hdr, hdr_n, rw, rw_n, mack, mack_n, oe, oe_n, hs, hs_n;
  logic [1:0] a_q, a_n;
  logic cap, cap_n;
  logic [IDX_W-1:0] idx, idx_n, bidx, bidx_n;
  logic bv_n, first, first_n, start_n, stop_n, ackd_n, txld_n;
  logic [7:0] rxb, rxb_n, full;

  assign full = {sr, sda_s};

  always_comb begin
    st_n = st; cnt_n = cnt; sr_n = sr; txsr_n = txsr;
    hdr_n = hdr; rw_n = rw; mack_n = mack; oe_n = oe; hs_n = hs;
    idx_n = idx; bidx_n = bidx; rxb_n = rxb; first_n = first;
    bv_n = 1'b0; start_n = 1'b0; stop_n = 1'b0; ackd_n = 1'b0; txld_n = 1'b0;
    a_n = a_q; cap_n = cap;
    if (!cap) begin
      a_n = addr_pins;
      cap_n = 1'b1;
    end
    if (stop_c) begin
      st_n = ST_IDLE; oe_n = 1'b0; hs_n = 1'b0; stop_n = 1'b1;
    end else if (start_c) begin
      st_n = ST_RX; cnt_n = '0; hdr_n = 1'b1; oe_n = 1'b0;
      idx_n = '0; start_n = 1'b1;
    end else begin
      case (st)
        ST_RX: if (scl_rise) begin
          sr_n  = full[6:0];
          cnt_n = cnt + 3'd1;
          if (cnt == 3'd7) begin
            cnt_n = '0;
            if (hdr) begin
              if (full[7:3] == HS_CODE) begin
                hs_n = 1'b1; st_n = ST_IDLE;
              end else if (full[7:1] == {ADDR_PREFIX, a_q}) begin
                rw_n = full[0]; st_n = ST_ACK_WAIT;
              end else if (full == BCAST) begin
                rw_n = 1'b0; st_n = ST_ACK_WAIT;
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              bv_n = 1'b1; rxb_n = full; bidx_n = idx;
              first_n = (idx == '0);
              if (idx != '1) idx_n = idx + 1'b1;
              st_n = ST_ACK_WAIT;
            end
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          oe_n = 1'b1; st_n = ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          ackd_n = 1'b1; hdr_n = 1'b0; cnt_n = '0;
          if (rw) begin
            txsr_n = tx_byte[6:0]; oe_n = ~tx_byte[7]; txld_n = 1'b1; st_n = ST_TX;
          end else begin
            oe_n = 1'b0; st_n = ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          if (cnt == 3'd7) begin
            oe_n = 1'b0; cnt_n = '0; st_n = ST_MACK;
          end else begin
            oe_n = ~txsr[6]; txsr_n = {txsr[5:0], 1'b0}; cnt_n = cnt + 3'd1;
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_n = ~sda_s;
          if (scl_fall) begin
            ackd_n = 1'b1;
            if (mack) begin
              txsr_n = tx_byte[6:0]; oe_n = ~tx_byte[7]; txld_n = 1'b1; st_n = ST_TX;
            end else begin
              oe_n = 1'b0; st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sr <= '0; txsr <= '0;
      hdr <= 1'b0; rw <= 1'b0; mack <= 1'b0; oe <= 1'b0; hs <= 1'b0;
      a_q <= '0; cap <= 1'b0; idx <= '0; bidx <= '0; rxb <= '0; first <= 1'b0;
      byte_valid <= 1'b0; start_seen <= 1'b0; stop_seen <= 1'b0;
      ack_done <= 1'b0; tx_load <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sr <= sr_n; txsr <= txsr_n;
      hdr <= hdr_n; rw <= rw_n; mack <= mack_n; oe <= oe_n; hs <= hs_n;
      a_q <= a_n; cap <= cap_n; idx <= idx_n; bidx <= bidx_n; rxb <= rxb_n;
      first <= first_n;
      byte_valid <= bv_n; start_seen <= start_n; stop_seen <= stop_n;
      ack_done <= ackd_n; tx_load <= txld_n;
    end

  assign sda_oe = oe;
  assign hs_mode = hs;
  assign rx_byte = rxb;
  assign byte_index = bidx;
  assign first_after_addr = first;

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != $past(oe)) |-> !$past(scl_s));
  assert_hs_stop_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !hs_mode);
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  assert_valid_then_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (st == ST_ACK_WAIT));
  assert_straps_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && $past(cap)) |-> $stable(a_q));
endmodule

// File: tb/i2cs_front_test.sv
module i2cs_front_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, scl, sda_m;
  logic [1:0] pins;
  logic [7:0] txb;
  logic sda_oe, hs_mode, start_seen, stop_seen, byte_valid, first_after_addr, ack_done, tx_load;
  logic [7:0] rx_byte;
  logic [3:0] byte_index;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2cs_front uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .addr_pins(pins),
    .tx_byte(txb), .sda_oe(sda_oe), .hs_mode(hs_mode), .start_seen(start_seen),
    .stop_seen(stop_seen), .byte_valid(byte_valid), .rx_byte(rx_byte),
    .byte_index(byte_index), .first_after_addr(first_after_addr),
    .ack_done(ack_done), .tx_load(tx_load));

  int n_run = 0, n_fail = 0;
  int n_start = 0, n_stop = 0, n_bv = 0, n_ackd = 0, n_txld = 0, viol = 0;
  logic [7:0] cb [16];
  int ci [16];
  bit cf [16];
  logic oe_prev = 1'b0, scl_prev = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_seen) n_start++;
      if (stop_seen) n_stop++;
      if (ack_done) n_ackd++;
      if (tx_load) n_txld++;
      if (byte_valid) begin
        if (n_bv < 16) begin
          cb[n_bv] = rx_byte; ci[n_bv] = int'(byte_index); cf[n_bv] = first_after_addr;
        end
        n_bv++;
      end
      if (sda_oe != oe_prev && scl && scl_prev) viol++;
    end
    oe_prev = sda_oe;
    scl_prev = scl;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; cyc(5); scl = 1'b1; cyc(10); sda_m = 1'b0; cyc(10); scl = 1'b0; cyc(5);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; cyc(5); scl = 1'b1; cyc(10); sda_m = 1'b1; cyc(10);
  endtask

  task automatic send(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; cyc(5); scl = 1'b1; cyc(10); scl = 1'b0; cyc(5);
    end
    sda_m = 1'b1; cyc(5); scl = 1'b1; cyc(5); acked = ~sda_line; cyc(5); scl = 1'b0; cyc(5);
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; cyc(5); scl = 1'b1; cyc(5); b[i] = sda_line; cyc(5); scl = 1'b0;
    end
    cyc(5); sda_m = give_ack ? 1'b0 : 1'b1; cyc(5); scl = 1'b1; cyc(10); scl = 1'b0; cyc(5);
    sda_m = 1'b1;
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
    chk(hs_mode == 1'b0, "R1", "hs_mode after reset", hs_mode, 0);
    chk((n_start + n_stop + n_bv + n_ackd + n_txld) == 0, "R1", "pulses after reset",
        n_start + n_stop + n_bv + n_ackd + n_txld, 0);
  endtask

  task automatic t_write_own;
    bit a;
    int s0 = n_start, p0 = n_stop, b0 = n_bv, k0 = n_ackd;
    logic [7:0] dat [3] = '{8'h12, 8'hA5, 8'h3C};
    bus_start;
    chk(n_start == s0 + 1, "R2", "start pulse count", n_start - s0, 1);
    send(8'h9C, a);
    chk(a, "R3", "own address ack", a, 1);
    for (int k = 0; k < 3; k++) begin
      send(dat[k], a);
      chk(a, "R7", "data byte ack", a, 1);
    end
    chk(n_bv == b0 + 3, "R7", "byte_valid count", n_bv - b0, 3);
    for (int k = 0; k < 3; k++) begin
      chk(cb[b0+k] == dat[k], "R7", "rx_byte", cb[b0+k], dat[k]);
      chk(ci[b0+k] == k, "R7", "byte_index", ci[b0+k], k);
      chk(cf[b0+k] == (k == 0), "R7", "first_after_addr", cf[b0+k], k == 0);
    end
    chk(n_ackd == k0 + 4, "R8", "ack_done count in write", n_ackd - k0, 4);
    bus_stop;
    chk(n_stop == p0 + 1, "R2", "stop pulse count", n_stop - p0, 1);
  endtask

  task automatic t_pins;
    bit a;
    pins = 2'b00;
    bus_start; send(8'h98, a); bus_stop;
    chk(!a, "R3", "address from new pins must be refused", a, 0);
    bus_start; send(8'h9C, a); bus_stop;
    chk(a, "R3", "captured address still answered", a, 1);
  endtask

  task automatic t_foreign;
    bit a;
    int b0;
    bus_start; send(8'h00, a);
    chk(!a, "R4", "general call refused", a, 0);
    b0 = n_bv;
    send(8'h55, a);
    chk(!a, "R4", "byte after mismatch not acked", a, 0);
    chk(n_bv == b0, "R4", "byte after mismatch not delivered", n_bv - b0, 0);
    bus_stop;
    bus_start; send(8'hF0, a); bus_stop;
    chk(!a, "R4", "10-bit prefix refused", a, 0);
  endtask

  task automatic t_bcast;
    bit a;
    int b0 = n_bv;
    bus_start; send(8'h90, a);
    chk(a, "R5", "broadcast write ack", a, 1);
    send(8'h77, a);
    chk(a && n_bv == b0 + 1 && cb[b0] == 8'h77, "R5", "broadcast data byte", cb[b0], 8'h77);
    bus_stop;
    bus_start; send(8'h91, a); bus_stop;
    chk(!a, "R5", "broadcast read refused", a, 0);
  endtask

  task automatic t_hs;
    bit a;
    bus_start; send(8'h09, a);
    chk(!a, "R6", "hs code not acked", a, 0);
    chk(hs_mode, "R6", "hs_mode set", hs_mode, 1);
    bus_start;
    chk(hs_mode, "R6", "hs_mode kept over repeated start", hs_mode, 1);
    send(8'h9C, a);
    chk(a, "R6", "address ack in hs mode", a, 1);
    send(8'h42, a);
    bus_start;
    chk(hs_mode, "R6", "hs_mode kept after second repeated start", hs_mode, 1);
    bus_stop;
    chk(!hs_mode, "R6", "hs_mode cleared by stop", hs_mode, 0);
  endtask

  task automatic t_read;
    bit a;
    logic [7:0] b;
    int l0 = n_txld, k0 = n_ackd;
    txb = 8'hC3;
    bus_start; send(8'h9D, a);
    chk(a, "R9", "read address ack", a, 1);
    chk(n_txld == l0 + 1, "R9", "tx_load after address", n_txld - l0, 1);
    txb = 8'h5A;
    recv(1'b1, b);
    chk(b == 8'hC3, "R9", "first read byte", b, 8'hC3);
    txb = 8'h00;
    recv(1'b0, b);
    chk(b == 8'h5A, "R10", "byte after master ack", b, 8'h5A);
    chk(n_txld == l0 + 2, "R10", "no load after NACK", n_txld - l0, 2);
    chk(n_ackd == k0 + 3, "R8", "ack_done count in read", n_ackd - k0, 3);
    recv(1'b0, b);
    chk(b == 8'hFF, "R10", "bus released after NACK", b, 8'hFF);
    chk(!sda_oe, "R10", "sda_oe after NACK", sda_oe, 0);
    bus_stop;
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; pins = 2'b10; txb = 8'h00;
    cyc(5);
    rst_n = 1'b1;
    cyc(20);
    t_reset;
    t_write_own;
    t_pins;
    t_foreign;
    t_bcast;
    t_hs;
    t_read;
    chk(viol == 0, "R11", "sda_oe changes while SCL high", viol, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule